// File: doc/BRIEF.md
# Generic Clock-Enable Generator Bank

This block holds eight independent clock generators that share one register port. Each generator takes one of four incoming source clock-enable strobes (two oscillators, two PLLs) and drives a single output. The output is either a 50% duty waveform at the source rate divided by an even ratio, or a one-cycle delayed copy of the selected strobe. All logic runs on one system clock. The sources arrive as one-cycle enable strobes, so no clock cell is muxed or gated.

Software programs each generator through its own 32-bit control word. Generator n sits at byte offset 4*n. The control word holds a run bit, two orthogonal source-select bits, a divide-enable bit and an 8-bit divide value. Stopping and reconfiguring are glitch-free at the level of the output waveform. A running high phase is never shortened, and new settings are applied only where a low phase begins.

Top module: `gclk_bank`

## Requirements
- R1: Eight control words of 32 bits sit at byte offsets 4*n, n = 0..7, where n is taken from addr_i[5:2]. A read returns the last value written to that word, and every word is 0 after reset.
- R2: For an address whose word index is 8 or more, a read returns 0 and a write changes no control word.
- R3: Bit 1 (bank select) and bit 2 (PLL select) together form a source index {bit2, bit1}. Index 0 is src_en_i[0] (oscillator 0), 1 is oscillator 1, 2 is PLL 0 and 3 is PLL 1.
- R4: Bit 0 is the run bit. A generator whose run bit is clear keeps its output low, and all outputs are low after reset.
- R5: With bit 3 (divide enable) set, the output toggles after every DIV+1 strobes of the selected source, where DIV is bits 15:8. The output period is therefore 2*(DIV+1) source strobes with equal high and low time.
- R6: With bit 3 clear, the output is high for exactly the cycle after each strobe of the selected source, so it runs at the source rate.
- R7: When the run bit is cleared while the divided output is high, the high phase runs to its full length and the output then stays low. If the output is low at that moment, it stops at once.
- R8: A change to the source select, the divide enable or DIV while a generator runs takes effect only at the start of the next low phase. The divide counter restarts from zero at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the control word at addr_i |
| addr_i | input | 6 | Byte address of the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_en_i | input | 4 | Source strobes: oscillator 0, oscillator 1, PLL 0, PLL 1 |
| gclk_o | output | 8 | One generated clock-enable waveform per generator |

## Verification
The hardest case to reach is a write that lands while a divided generator is in the middle of a phase. The write must be held back through the rest of that low phase and the following high phase, so the bench has to place it at a known point in the waveform. To do this, the bench watches the output for a falling edge, issues the write inside the low phase that follows, and then logs the lengths of the next runs. The first full high phase must still show the old ratio and only the next low phase the new one. Stopping a generator during a high phase is reached the same way: the run bit is cleared a few cycles after an observed rising edge of a slow generator.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
  // control word field positions
  localparam int CEN_BIT  = 0;
  localparam int OSEL_BIT = 1;  // bank select, low bit of source index
  localparam int PSEL_BIT = 2;  // PLL select, high bit of source index
  localparam int DEN_BIT  = 3;
  localparam int DIV_LSB  = 8;

  typedef enum logic [1:0] {
    SRC_OSC0 = 2'd0,
    SRC_OSC1 = 2'd1,
    SRC_PLL0 = 2'd2,
    SRC_PLL1 = 2'd3
  } src_e;
endpackage

// File: rtl/gclk_regs.sv
module gclk_regs #(
  parameter int N_GEN  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [N_GEN-1:0][DATA_W-1:0]  ctrl_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]                idx;
  logic [N_GEN-1:0]                wr_sel;
  logic [N_GEN-1:0][DATA_W-1:0]    ctrl_q;

  assign idx = addr_i[ADDR_W-1:2];

  for (genvar n = 0; n < N_GEN; n++) begin : g_reg
    assign wr_sel[n] = we_i && (idx == IDX_W'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ctrl_q[n] <= '0;
      else if (wr_sel[n]) ctrl_q[n] <= wdata_i;
    end

    a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_sel[n] |=> ctrl_q[n] == $past(wdata_i));
  end

  // full decode: indices past the last generator read as zero
  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < N_GEN; n++)
      if (idx == IDX_W'(n)) rdata_o = ctrl_q[n];
  end

  assign ctrl_o = ctrl_q;

  a_r2_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel));
  a_r2_oob_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (int'(idx) >= N_GEN)) |=> $stable(ctrl_q));
endmodule

// File: rtl/gclk_src_sel.sv
module gclk_src_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  assign tick_o = src_en_i[sel_i];
endmodule

// File: rtl/gclk_div.sv
module gclk_div #(
  parameter int DIV_W = 8,
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             den_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [N_SRC-1:0] src_en_i,
  output logic             gclk_o
);
  // active (shadow) configuration, reloaded only where a low phase begins
  logic [SEL_W-1:0] sel_q;
  logic             den_q;
  logic [DIV_W-1:0] div_q;

  logic             run_q, run_n;
  logic             out_q, out_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             load;
  logic             tick;

  gclk_src_sel #(.N_SRC(N_SRC)) u_sel (
    .src_en_i (src_en_i),
    .sel_i    (sel_q),
    .tick_o   (tick)
  );

  always_comb begin
    run_n = run_q;
    out_n = out_q;
    cnt_n = cnt_q;
    load  = 1'b0;
    if (!run_q) begin
      out_n = 1'b0;
      cnt_n = '0;
      load  = 1'b1;
      run_n = cen_i;
    end else if (!den_q) begin
      if (!cen_i) begin
        run_n = 1'b0;
        out_n = 1'b0;
      end else begin
        out_n = tick;
        if (!tick) begin
          load  = 1'b1;
          cnt_n = '0;
        end
      end
    end else if (!out_q && !cen_i) begin
      run_n = 1'b0;
      out_n = 1'b0;
      cnt_n = '0;
    end else if (tick) begin
      if (cnt_q == div_q) begin
        cnt_n = '0;
        out_n = ~out_q;
        if (out_q) begin
          if (!cen_i) run_n = 1'b0;
          else        load  = 1'b1;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
      cnt_q <= '0;
      sel_q <= '0;
      den_q <= 1'b0;
      div_q <= '0;
    end else begin
      run_q <= run_n;
      out_q <= out_n;
      cnt_q <= cnt_n;
      if (load) begin
        sel_q <= sel_i;
        den_q <= den_i;
        div_q <= div_i;
      end
    end
  end

  assign gclk_o = out_q;

  a_r4_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !out_q);
  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && den_q) |-> cnt_q <= div_q);
  a_r7_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && den_q && out_q && !tick) |=> out_q);
  a_r8_cfg_at_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(div_q) || !$stable(den_q) || !$stable(sel_q)) |-> !out_q);
endmodule

// File: rtl/gclk_bank.sv
module gclk_bank
  import gclk_pkg::*;
#(
  parameter int N_GEN  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int N_SRC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_en_i,
  output logic [N_GEN-1:0]  gclk_o
);
  localparam int SEL_W = $clog2(N_SRC);

  logic [N_GEN-1:0][DATA_W-1:0] ctrl;

  gclk_regs #(
    .N_GEN  (N_GEN),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl)
  );

  for (genvar n = 0; n < N_GEN; n++) begin : g_gen
    gclk_div #(
      .DIV_W (DIV_W),
      .N_SRC (N_SRC)
    ) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cen_i    (ctrl[n][CEN_BIT]),
      .sel_i    (ctrl[n][OSEL_BIT +: SEL_W]),
      .den_i    (ctrl[n][DEN_BIT]),
      .div_i    (ctrl[n][DIV_LSB +: DIV_W]),
      .src_en_i (src_en_i),
      .gclk_o   (gclk_o[n])
    );

    a_r4_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl[n][CEN_BIT] && !gclk_o[n]) |=> !gclk_o[n]);
  end
endmodule

// File: tb/gclk_bank_tb.sv
module gclk_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  src_en = '0;
  logic [7:0]  gclk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int fc       = 0;

  always #5 clk = ~clk;

  gclk_bank u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .src_en_i (src_en),
    .gclk_o   (gclk)
  );

  // sources: osc0 every cycle, osc1 every 2nd, pll0 every 3rd, pll1 every 4th
  always @(negedge clk) begin
    fc <= fc + 1;
    src_en[0] <= 1'b1;
    src_en[1] <= ((fc + 1) % 2) == 0;
    src_en[2] <= ((fc + 1) % 3) == 0;
    src_en[3] <= ((fc + 1) % 4) == 0;
  end

  // per generator: source, divide enable, DIV, expected high cycles and rising edges in 480 cycles
  localparam int T_SRC  [8] = '{0, 1, 2, 3, 2, 0, 3, 1};
  localparam int T_DEN  [8] = '{1, 1, 1, 1, 0, 0, 1, 1};
  localparam int T_DIV  [8] = '{0, 1, 3, 4, 0, 0, 1, 59};
  localparam int T_HI   [8] = '{240, 240, 240, 240, 160, 480, 240, 240};
  localparam int T_RISE [8] = '{240, 60, 20, 12, 160, 0, 30, 2};
  localparam int WIN = 480;

  function automatic logic [31:0] mk(bit cen, int src, bit den, int dv);
    return {16'h0, 8'(dv), 4'b0, den, 2'(src), cen};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  int hi_cnt [8];
  int rise_cnt [8];
  int runs [4];

  // collect lengths of the next 4 constant-level runs of generator g
  task automatic collect_runs(int g);
    bit prev;
    int len;
    int k;
    @(negedge clk);
    prev = gclk[g]; len = 1; k = 0;
    for (int c = 0; c < 400 && k < 4; c++) begin
      @(negedge clk);
      if (gclk[g] == prev) len++;
      else begin
        runs[k] = len; k++; len = 1; prev = gclk[g];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit prev [8];
    bit found;
    repeat (3) @(negedge clk);
    // R4: outputs low in reset
    chk(gclk == 8'h00, "R4 reset outputs", gclk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset value of control words
    rd(6'd12, d);
    chk(d == 32'h0, "R1 reset readback", d, 0);

    // R1: readback of an arbitrary pattern
    wr(6'd20, 32'hA5A5_5A00);
    rd(6'd20, d);
    chk(d == 32'hA5A5_5A00, "R1 readback", d, 32'hA5A5_5A00);
    // R4: run bit clear, output stays low
    repeat (20) @(negedge clk);
    chk(gclk[5] == 1'b0, "R4 disabled low", gclk[5], 0);

    // R2: out-of-range write ignored, read zero
    wr(6'd0, 32'h0000_1234);
    wr(6'd32, 32'hFFFF_FFFF);
    rd(6'd32, d);
    chk(d == 32'h0, "R2 oob read", d, 0);
    rd(6'd0, d);
    chk(d == 32'h0000_1234, "R2 oob write ignored", d, 32'h1234);
    rd(6'd60, d);
    chk(d == 32'h0, "R2 oob top read", d, 0);
    chk(gclk == 8'h00, "R2 outputs untouched", gclk, 0);

    // R3 R5 R6: table of configurations, measured together
    for (int g = 0; g < 8; g++)
      wr(6'(4 * g), mk(1'b1, T_SRC[g], T_DEN[g] != 0, T_DIV[g]));
    repeat (300) @(negedge clk);
    for (int g = 0; g < 8; g++) begin
      prev[g] = gclk[g]; hi_cnt[g] = 0; rise_cnt[g] = 0;
    end
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      for (int g = 0; g < 8; g++) begin
        if (gclk[g]) hi_cnt[g]++;
        if (gclk[g] && !prev[g]) rise_cnt[g]++;
        prev[g] = gclk[g];
      end
    end
    for (int g = 0; g < 8; g++) begin
      chk(hi_cnt[g] == T_HI[g], T_DEN[g] != 0 ? "R5 high cycles" : "R6 high cycles",
          hi_cnt[g], T_HI[g]);
      chk(rise_cnt[g] == T_RISE[g], T_DEN[g] != 0 ? "R3 R5 rising edges" : "R3 R6 rising edges",
          rise_cnt[g], T_RISE[g]);
    end

    // R8: reconfigure inside a low phase, old ratio must survive one more high phase
    wr(6'd12, mk(1'b1, 0, 1'b1, 9));
    repeat (100) @(negedge clk);
    found = 1'b0;
    prev[3] = gclk[3];
    for (int c = 0; c < 200 && !found; c++) begin
      @(negedge clk);
      if (prev[3] && !gclk[3]) found = 1'b1;
      prev[3] = gclk[3];
    end
    chk(found, "R8 falling edge seen", found, 1);
    we = 1'b1; addr = 6'd12; wdata = mk(1'b1, 0, 1'b1, 1);
    @(negedge clk);
    we = 1'b0;
    collect_runs(3);
    chk(runs[1] == 10, "R8 old high phase kept", runs[1], 10);
    chk(runs[2] == 2, "R8 new low phase", runs[2], 2);
    chk(runs[3] == 2, "R8 new high phase", runs[3], 2);

    // R7: stop during a long high phase
    found = 1'b0;
    prev[7] = gclk[7];
    for (int c = 0; c < 600 && !found; c++) begin
      @(negedge clk);
      if (!prev[7] && gclk[7]) found = 1'b1;
      prev[7] = gclk[7];
    end
    chk(found, "R7 rising edge seen", found, 1);
    repeat (10) @(negedge clk);
    wr(6'd28, mk(1'b0, 1, 1'b1, 59));
    repeat (20) @(negedge clk);
    chk(gclk[7] == 1'b1, "R7 high phase not cut", gclk[7], 1);
    repeat (150) @(negedge clk);
    chk(gclk[7] == 1'b0, "R7 low after stop", gclk[7], 0);
    hi_cnt[7] = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (gclk[7]) hi_cnt[7]++;
    end
    chk(hi_cnt[7] == 0, "R7 stays low", hi_cnt[7], 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule